// File: doc/BRIEF.md
# Two-Wire Switch-Enable Register Slave

This block is a target on a two-wire serial bus that owns one byte of switch enables. A bus master addresses it with a seven-bit address. The top five bits of that address are fixed at `10010`, and the low two bits come from two strap pins. The master can then overwrite the byte or read it back. Each output bit turns one analog switch on when it is 1. Output bit 7 drives switch 8 and bit 0 drives switch 1.

The block runs on a fast system clock and oversamples both bus lines. Each line first passes through a synchronizer and then a stability filter, so pulses shorter than a configurable number of system clocks are rejected. During a write, each data byte reaches the outputs as soon as its eighth bit is sampled. Every further byte in the same addressed write replaces the outputs again. During a read, the current register value is returned most significant bit first. If the master acknowledges, the value is sent again. If the master does not acknowledge, the block lets go of the line and waits for STOP or a new START. An active-low clear input turns every switch off.

Top module: `i2c_swctl`

## Requirements
- R1: The block acknowledges an address byte whose upper seven bits, sent first, equal `1,0,0,1,0,strap_a1,strap_a0`. It acknowledges by asserting `sda_pull` so that the data line is low throughout the high phase of the ninth clock.
- R2: After an address that does not match, the block gives no acknowledge, ignores every later byte, and leaves `sw_en` unchanged until the next START.
- R3: In a write (last address bit 0), each received data byte appears on `sw_en` before its acknowledge clock. Each further byte in the same transaction replaces it again.
- R4: The first data bit on the wire lands in `sw_en[7]` (switch 8) and the last in `sw_en[0]` (switch 1). A 1 means on.
- R5: In a read (last address bit 1), the block shifts out the live register MSB first. A master acknowledge (0) repeats the byte. A master no-acknowledge (1) leaves the line released until STOP or START.
- R6: A START is the data line falling while the clock is high, and a STOP is the data line rising while the clock is high. A repeated START at any point restarts address reception, and a partial data byte is discarded.
- R7: While `clr_n` is low at a clock edge, the register goes to zero, the line is released and the engine returns to idle.
- R8: After `rst_n`, `sw_en` is 0 and `sda_pull` is 0.
- R9: A level on either bus line shorter than `STABLE_CYCLES` system clocks has no effect on the protocol.
- R10: The block changes `sda_pull` only after a filtered clock fall, a START, a STOP or a clear, and it asserts it only while the filtered clock is low.
- R11: Every data byte of an addressed write is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| clr_n | input | 1 | Synchronous active-low clear of the switch register |
| scl_in | input | 1 | Bus clock line as received |
| sda_in | input | 1 | Bus data line as received (wired level) |
| strap_a1 | input | 1 | Address bit 1 strap |
| strap_a0 | input | 1 | Address bit 0 strap |
| sda_pull | output | 1 | 1 means drive the data line low (open-drain enable) |
| sw_en | output | 8 | Switch enables, bit 7 = switch 8, bit 0 = switch 1 |

## Verification
The bench targets addresses that differ only in the strap bits or only in the fixed prefix. A design that compared too few bits would acknowledge them and overwrite the switches. It also breaks off a write halfway with a repeated START and then reads the register back. An engine that committed partial bytes, or did not re-enter address reception, would return the wrong value. Short spikes are injected on the clock during a low phase and on the data line during a high phase. An unfiltered design would count an extra bit or see a false START or STOP, and so corrupt the written byte. Read tests cover both a master acknowledge and a no-acknowledge. These catch a slave that stops after one byte or keeps driving after the no-acknowledge.

// File: rtl/i2c_swctl_pkg.sv
// Shared constants and engine state encoding for the switch-enable bus slave.
package i2c_swctl_pkg;

    localparam int          BYTE_W      = 8;
    localparam int          PREFIX_W    = 5;
    localparam logic [4:0]  ADDR_PREFIX = 5'b10010;
    localparam int          BITCNT_W    = $clog2(BYTE_W + 1);

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR,
        ST_WR_ACK,
        ST_RD,
        ST_RD_MACK,
        ST_RD_NEXT,
        ST_WAIT
    } eng_state_t;

endpackage

// File: rtl/i2c_swctl_filter.sv
// Synchronizes one bus line into the system clock domain and passes a new level
// only after it has been seen on STABLE_CYCLES consecutive clocks.
// Assumes the bus line idles at IDLE_LEVEL and that STABLE_CYCLES >= 1.
module i2c_swctl_filter #(
    parameter int   STABLE_CYCLES = 13,
    parameter logic IDLE_LEVEL    = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic line_out
);

    localparam int CNT_W = $clog2(STABLE_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STABLE_CYCLES - 1);

    logic [1:0]       sync_q;
    logic [CNT_W-1:0] run_cnt;
    logic             level_q;

    // Two-flop synchronizer against metastability on the raw line.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= {2{IDLE_LEVEL}};
        else        sync_q <= {sync_q[0], line_in};
    end

    // Count how long the synchronized level has differed; accept it once it has held long enough.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt <= '0;
            level_q <= IDLE_LEVEL;
        end else if (sync_q[1] == level_q) begin
            run_cnt <= '0;
        end else if (run_cnt == CNT_LAST) begin
            run_cnt <= '0;
            level_q <= sync_q[1];
        end else begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    assign line_out = level_q;

endmodule

// File: rtl/i2c_swctl_cond.sv
// Turns the filtered clock and data levels into single-cycle event strobes:
// clock rise, clock fall, START and STOP. Assumes both inputs are already
// synchronous and glitch-free.
module i2c_swctl_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic scl_rise,
    output logic scl_fall,
    output logic bus_start,
    output logic bus_stop
);

    logic scl_q;
    logic sda_q;

    // Keep the previous filtered levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    // Decode edges; data transitions count as conditions only with the clock held high.
    always_comb begin
        scl_rise  = scl_f & ~scl_q;
        scl_fall  = ~scl_f & scl_q;
        bus_start = scl_f & scl_q & sda_q & ~sda_f;
        bus_stop  = scl_f & scl_q & ~sda_q & sda_f;
    end

endmodule

// File: rtl/i2c_swctl_engine.sv
// Protocol engine and switch register. Samples data on filtered clock rises,
// changes its own drive on filtered clock falls, and decodes address, write and
// read phases. Assumes the event strobes are one clock wide.
module i2c_swctl_engine
    import i2c_swctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_n,
    input  logic              sda_f,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              bus_start,
    input  logic              bus_stop,
    input  logic [1:0]        strap,
    output logic              sda_pull,
    output logic [BYTE_W-1:0] sw_reg
);

    localparam logic [BITCNT_W-1:0] LAST_BIT = BITCNT_W'(BYTE_W - 1);
    localparam logic [BITCNT_W-1:0] ALL_BITS = BITCNT_W'(BYTE_W);

    eng_state_t          state;
    logic [BITCNT_W-1:0] bitcnt;
    logic [BYTE_W-1:0]   rx_sh;
    logic [BYTE_W-1:0]   tx_sh;
    logic                is_read;
    logic [BYTE_W-1:0]   rx_byte;
    logic                addr_hit;

    // Byte completed by the current sample, and whether it names this target.
    always_comb begin
        rx_byte  = {rx_sh[BYTE_W-2:0], sda_f};
        addr_hit = (rx_sh[BYTE_W-2 -: PREFIX_W] == ADDR_PREFIX) && (rx_sh[1:0] == strap);
    end

    // Main bus sequencer: conditions first, then per-state clock-edge handling.
    always_ff @(posedge clk) begin
        if (!rst_n || !clr_n) begin
            state    <= ST_IDLE;
            bitcnt   <= '0;
            rx_sh    <= '0;
            tx_sh    <= '0;
            is_read  <= 1'b0;
            sda_pull <= 1'b0;
            sw_reg   <= '0;
        end else if (bus_start) begin
            state    <= ST_ADDR;
            bitcnt   <= '0;
            sda_pull <= 1'b0;
        end else if (bus_stop) begin
            state    <= ST_IDLE;
            sda_pull <= 1'b0;
        end else begin
            case (state)
                ST_ADDR: begin
                    if (scl_rise) begin
                        rx_sh <= rx_byte;
                        if (bitcnt == LAST_BIT) begin
                            bitcnt  <= '0;
                            is_read <= sda_f;
                            state   <= addr_hit ? ST_ADDR_ACK : ST_IDLE;
                        end else begin
                            bitcnt <= bitcnt + 1'b1;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        if (!sda_pull) begin
                            sda_pull <= 1'b1;
                        end else if (is_read) begin
                            tx_sh    <= sw_reg;
                            sda_pull <= ~sw_reg[BYTE_W-1];
                            bitcnt   <= '0;
                            state    <= ST_RD;
                        end else begin
                            sda_pull <= 1'b0;
                            bitcnt   <= '0;
                            state    <= ST_WR;
                        end
                    end
                end
                ST_WR: begin
                    if (scl_rise) begin
                        rx_sh <= rx_byte;
                        if (bitcnt == LAST_BIT) begin
                            sw_reg <= rx_byte;
                            bitcnt <= '0;
                            state  <= ST_WR_ACK;
                        end else begin
                            bitcnt <= bitcnt + 1'b1;
                        end
                    end
                end
                ST_WR_ACK: begin
                    if (scl_fall) begin
                        if (!sda_pull) begin
                            sda_pull <= 1'b1;
                        end else begin
                            sda_pull <= 1'b0;
                            state    <= ST_WR;
                        end
                    end
                end
                ST_RD: begin
                    if (scl_rise) begin
                        bitcnt <= bitcnt + 1'b1;
                    end else if (scl_fall) begin
                        if (bitcnt == ALL_BITS) begin
                            sda_pull <= 1'b0;
                            state    <= ST_RD_MACK;
                        end else begin
                            tx_sh    <= {tx_sh[BYTE_W-2:0], 1'b0};
                            sda_pull <= ~tx_sh[BYTE_W-2];
                        end
                    end
                end
                ST_RD_MACK: begin
                    if (scl_rise) state <= sda_f ? ST_WAIT : ST_RD_NEXT;
                end
                ST_RD_NEXT: begin
                    if (scl_fall) begin
                        tx_sh    <= sw_reg;
                        sda_pull <= ~sw_reg[BYTE_W-1];
                        bitcnt   <= '0;
                        state    <= ST_RD;
                    end
                end
                default: begin
                    sda_pull <= 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/i2c_swctl.sv
// Top of the two-wire switch-enable slave: one glitch filter per bus line,
// an event decoder and the protocol engine. Assumes sda_in is the wired bus
// level, which already includes this block's own pull-down.
module i2c_swctl
    import i2c_swctl_pkg::*;
#(
    parameter int STABLE_CYCLES = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_n,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic              strap_a1,
    input  logic              strap_a0,
    output logic              sda_pull,
    output logic [BYTE_W-1:0] sw_en
);

    localparam int N_LINES = 2;

    logic [N_LINES-1:0] raw_lines;
    logic [N_LINES-1:0] filt_lines;
    logic               scl_f;
    logic               sda_f;
    logic               scl_rise;
    logic               scl_fall;
    logic               bus_start;
    logic               bus_stop;

    assign raw_lines = {sda_in, scl_in};

    // One identical filter per bus line.
    for (genvar li = 0; li < N_LINES; li++) begin : g_filt
        i2c_swctl_filter #(
            .STABLE_CYCLES(STABLE_CYCLES),
            .IDLE_LEVEL   (1'b1)
        ) u_filt (
            .clk     (clk),
            .rst_n   (rst_n),
            .line_in (raw_lines[li]),
            .line_out(filt_lines[li])
        );
    end

    assign scl_f = filt_lines[0];
    assign sda_f = filt_lines[1];

    i2c_swctl_cond u_cond (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_f    (scl_f),
        .sda_f    (sda_f),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .bus_start(bus_start),
        .bus_stop (bus_stop)
    );

    i2c_swctl_engine u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_n    (clr_n),
        .sda_f    (sda_f),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .bus_start(bus_start),
        .bus_stop (bus_stop),
        .strap    ({strap_a1, strap_a0}),
        .sda_pull (sda_pull),
        .sw_reg   (sw_en)
    );

endmodule

// File: rtl/i2c_swctl_chk.sv
// Property checker for the switch-enable slave, bound to the top module.
// Assumes STABLE_CYCLES is at least 5, so an accepted level was already present
// at the raw input four clocks earlier.
module i2c_swctl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       clr_n,
    input logic       scl_in,
    input logic       scl_f,
    input logic       scl_rise,
    input logic       scl_fall,
    input logic       bus_start,
    input logic       bus_stop,
    input logic       sda_pull,
    input logic [7:0] sw_en
);

    // R7
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |=> (sw_en == 8'h00 && !sda_pull));

    // R3
    sw_update_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sw_en) |-> ($past(scl_rise) || !$past(clr_n)));

    // R10
    drive_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pull) |-> ($past(scl_fall) || $past(bus_start) || $past(bus_stop) || !$past(clr_n)));

    // R10
    pull_clk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull) |-> !scl_f);

    // R9
    glitch_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(scl_f) |-> ($past(scl_in, 4) == scl_f));

endmodule

bind i2c_swctl i2c_swctl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_n    (clr_n),
    .scl_in   (scl_in),
    .scl_f    (scl_f),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .bus_start(bus_start),
    .bus_stop (bus_stop),
    .sda_pull (sda_pull),
    .sw_en    (sw_en)
);

// File: tb/i2c_swctl_test.sv
module i2c_swctl_test;

    localparam int FILT = 13;
    localparam int Q    = 30;
    localparam int GL   = 8;
    localparam int NVEC = 6;
    // {address[6:0], data[7:0]}; straps are 1,0 for this table
    localparam logic [14:0] VEC [NVEC] = '{
        {7'h4A, 8'hA5}, {7'h5A, 8'h3C}, {7'h4A, 8'h00},
        {7'h4A, 8'hFF}, {7'h49, 8'h12}, {7'h4A, 8'h81}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clr_n = 1'b1;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic a1 = 1'b1;
    logic a0 = 1'b0;
    logic glitch_en = 1'b0;
    logic done = 1'b0;
    logic sda_pull;
    logic [7:0] sw_en;
    wire sda_line = sda_m & ~sda_pull;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] model = 8'h00;

    always #2 clk = ~clk;

    i2c_swctl #(.STABLE_CYCLES(FILT)) uut (
        .clk(clk), .rst_n(rst_n), .clr_n(clr_n),
        .scl_in(scl_m), .sda_in(sda_line),
        .strap_a1(a1), .strap_a0(a0),
        .sda_pull(sda_pull), .sw_en(sw_en)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b;
        if (glitch_en) begin
            tick(10); scl_m = 1'b1; tick(GL); scl_m = 1'b0; tick(Q - 10 - GL);
        end else tick(Q);
        scl_m = 1'b1;
        if (glitch_en) begin
            tick(10); sda_m = ~b; tick(GL); sda_m = b; tick(2 * Q - 10 - GL);
        end else tick(2 * Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic write_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
        acked = (sda_line == 1'b0);
        tick(Q); scl_m = 1'b0; tick(Q);
    endtask

    task automatic read_byte(input logic mnack, output logic [7:0] v);
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
            v[i] = sda_line;
            tick(Q); scl_m = 1'b0; tick(Q);
        end
        send_bit(mnack);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin : main
        logic ack;
        logic [7:0] rd;
        logic [6:0] own;
        tick(5); rst_n = 1'b1; tick(3);
        // R8 reset state
        check("R8", "sw_en after reset", sw_en, 8'h00);
        check("R8", "sda_pull after reset", {7'b0, sda_pull}, 8'h00);

        // Vector table: R1 address match, R2 mismatch, R3 update, R11 data ack
        for (int i = 0; i < NVEC; i++) begin
            logic [6:0] va;
            logic [7:0] vd;
            logic exp_ack;
            va = VEC[i][14:8];
            vd = VEC[i][7:0];
            exp_ack = (va == {5'b10010, a1, a0});
            bus_start();
            write_byte({va, 1'b0}, ack);
            check("R1", "address ack", {7'b0, ack}, {7'b0, exp_ack});
            write_byte(vd, ack);
            check("R11", "data ack", {7'b0, ack}, {7'b0, exp_ack});
            if (exp_ack) model = vd;
            check("R2", "sw_en after byte", sw_en, model);
            bus_stop();
            check("R3", "sw_en after stop", sw_en, model);
        end

        own = {5'b10010, a1, a0};
        // R3 several bytes in one write, each updates
        bus_start();
        write_byte({own, 1'b0}, ack);
        write_byte(8'h11, ack);
        check("R3", "first byte of burst", sw_en, 8'h11);
        write_byte(8'h22, ack);
        check("R3", "second byte of burst", sw_en, 8'h22);
        write_byte(8'h80, ack);
        // R4 first bit on the wire is switch 8
        check("R4", "bit order switch 8 only", sw_en, 8'h80);
        bus_stop();
        model = 8'h80;

        // R5 read back with master ack then no-ack
        bus_start();
        write_byte({own, 1'b0}, ack);
        write_byte(8'h5C, ack);
        bus_stop();
        model = 8'h5C;
        bus_start();
        write_byte({own, 1'b1}, ack);
        check("R5", "read address ack", {7'b0, ack}, 8'h01);
        read_byte(1'b0, rd);
        check("R5", "read first byte", rd, 8'h5C);
        read_byte(1'b1, rd);
        check("R5", "read repeated byte", rd, 8'h5C);
        for (int k = 0; k < 2; k++) begin
            sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
            check("R5", "line released after no-ack", {7'b0, sda_line}, 8'h01);
            tick(Q); scl_m = 1'b0; tick(Q);
        end
        bus_stop();

        // R6 repeated START mid-byte discards partial byte, restarts address
        bus_start();
        write_byte({own, 1'b0}, ack);
        for (int k = 0; k < 4; k++) send_bit(1'b0);
        bus_start();
        write_byte({own, 1'b1}, ack);
        check("R6", "ack after repeated start", {7'b0, ack}, 8'h01);
        read_byte(1'b1, rd);
        check("R6", "partial byte discarded", rd, model);
        bus_stop();

        // R1 strap change moves the address
        a1 = 1'b0; a0 = 1'b1;
        tick(4);
        bus_start();
        write_byte({7'h4A, 1'b0}, ack);
        check("R1", "old address after strap change", {7'b0, ack}, 8'h00);
        bus_stop();
        bus_start();
        write_byte({7'h49, 1'b0}, ack);
        check("R1", "new strap address ack", {7'b0, ack}, 8'h01);
        write_byte(8'h3A, ack);
        bus_stop();
        check("R1", "write via new address", sw_en, 8'h3A);

        // R9 short spikes on both lines during a data byte
        bus_start();
        write_byte({7'h49, 1'b0}, ack);
        glitch_en = 1'b1;
        write_byte(8'h96, ack);
        glitch_en = 1'b0;
        check("R9", "byte through spikes", sw_en, 8'h96);
        check("R9", "ack through spikes", {7'b0, ack}, 8'h01);
        bus_stop();

        // R7 clear
        clr_n = 1'b0; tick(3); clr_n = 1'b1; tick(2);
        check("R7", "sw_en after clear", sw_en, 8'h00);
        check("R7", "line released after clear", {7'b0, sda_pull}, 8'h00);
        bus_start();
        write_byte({7'h49, 1'b0}, ack);
        write_byte(8'h07, ack);
        bus_stop();
        check("R7", "write after clear", sw_en, 8'h07);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule